// File: doc/BRIEF.md
# ROM and Page-Mode DRAM Access Sequencer

This block sits between a processor core and external memory. It decides how many clock cycles each core access takes and drives the strobes that frame it. The address space has two region types, and the top address bit selects between them.

The ROM region is split into four banks. Each bank has its own wait-state counts for reads and for writes, and can optionally run one-cycle burst beats. The DRAM region opens a row on a first access. That first access is shortened when the row precharge was already absorbed in an idle cycle. Accesses that follow it, to the next address in the same row, complete in one cycle each.

The core raises `req` and holds the address and direction stable until it sees `rdy`. A back-to-back request presented in the cycle right after `rdy` is a candidate for a burst beat.

Top module: `rom_dram_seq`

## Requirements
- R1: After reset, every ROM bank takes 4 cycles per access for both reads and writes, and burst is disabled, so even consecutive back-to-back addresses take 4 cycles each. An access's length is counted from the first cycle `req` is high through the cycle `rdy` is high.
- R2: A configuration write (`cfg_we` high for one cycle) sets the bank selected by `cfg_bank` to read wait states `cfg_rws` and write wait states `cfg_wws`, each 0 to 3. A read then takes rws+1 cycles and a write wws+1 cycles. Each bank keeps its own values.
- R3: When `cfg_burst` is set for a bank, a ROM request is a one-cycle beat when all of the following hold: it arrives in the cycle directly after `rdy`, its address is the previous address plus one, it has the same direction, and it is in the same bank. A gap, a jump or a direction change brings back the full wait-state length.
- R4: A DRAM first access takes 3 cycles when the cycle before it had the row strobe asserted (no idle cycle in between).
- R5: A DRAM first access takes 2 cycles when at least one preceding cycle had `ras_n` high, including cycles spent on ROM accesses.
- R6: A DRAM request is a one-cycle page-mode beat when all of the following hold: it arrives in the cycle directly after `rdy`, its address is the previous address plus one, it has the same direction, and it lies in the same row. The row is the address bits above the COLW low column bits.
- R7: A DRAM request that leaves the open row, jumps to a non-consecutive address or changes direction is a full first access.
- R8: `rdy` is high only while `req` is high, once per access. During a DRAM request `ras_n` is low, and `cas_n` is low exactly in the DRAM cycle where `rdy` is high.
- R9: `rom_ce_n[b]` is low, and all other bits are high, only while a ROM request addresses bank b; bank b is address bits AW-2:AW-3. With no ROM request all chip enables are high, and `ras_n` is high whenever no DRAM request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Core access request, held until rdy |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address; top bit 1 selects DRAM |
| cfg_we | input | 1 | ROM bank configuration write strobe |
| cfg_bank | input | 2 | Bank being configured |
| cfg_rws | input | 2 | Read wait states |
| cfg_wws | input | 2 | Write wait states |
| cfg_burst | input | 1 | Burst enable for the bank |
| rdy | output | 1 | Final cycle of an access or beat |
| ras_n | output | 1 | Row strobe, low while a DRAM request is present |
| cas_n | output | 1 | Column strobe, low on the final DRAM cycle |
| rom_ce_n | output | 4 | Per-bank ROM chip enable, active low |

## Verification
Two decisions can fall on the same clock edge. One is marking the row precharge as already done. The other is starting a DRAM first access. A ROM access followed back to back by a DRAM access provokes this, because the ROM cycle with `ras_n` high arms the shortcut just as the DRAM request appears. The bench expects 2 cycles there, and 3 cycles when a DRAM access follows another DRAM access with no gap. Burst-chain detection also coincides with the previous `rdy`: beats are judged by cycle counts, and so are the full lengths that must return after a gap, a jump, a direction change or a row crossing.

// File: rtl/rom_dram_seq.sv
module rom_dram_seq #(
  parameter int AW   = 12,
  parameter int COLW = 4,
  parameter int WSW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_bank,
  input  logic [WSW-1:0] cfg_rws,
  input  logic [WSW-1:0] cfg_wws,
  input  logic          cfg_burst,
  output logic          rdy,
  output logic          ras_n,
  output logic          cas_n,
  output logic [3:0]    rom_ce_n
);
  localparam int NBANK = 4;
  localparam int BKW   = 2;
  localparam int RGN   = AW - 1;
  localparam int CNTW  = WSW + 1;

  logic [WSW-1:0]  rws [NBANK];
  logic [WSW-1:0]  wws [NBANK];
  logic [NBANK-1:0] ben;

  logic [AW-1:0]   last_addr;
  logic            last_wr, prev_rdy, in_acc, pre_done;
  logic [CNTW-1:0] need_q, elapsed, need_c, rom_len, dram_len;

  wire           is_dram  = addr[RGN];
  wire [BKW-1:0] bank     = addr[RGN-1 -: BKW];
  wire [AW-1:0]  nxt      = last_addr + 1'b1;
  wire           seq      = prev_rdy && addr == nxt && wr == last_wr &&
                            addr[RGN] == last_addr[RGN];
  wire           same_row = addr[AW-1:COLW] == last_addr[AW-1:COLW];
  wire           same_bk  = bank == last_addr[RGN-1 -: BKW];

  always_comb begin
    if (seq && same_bk && ben[bank]) rom_len = CNTW'(1);
    else rom_len = (wr ? {1'b0, wws[bank]} : {1'b0, rws[bank]}) + 1'b1;
    if (seq && same_row)  dram_len = CNTW'(1);
    else if (pre_done)    dram_len = CNTW'(2);
    else                  dram_len = CNTW'(3);
    need_c = is_dram ? dram_len : rom_len;
  end

  assign rdy   = req && (in_acc ? (elapsed == need_q - 1'b1) : (need_c == CNTW'(1)));
  assign ras_n = !(req && is_dram);
  assign cas_n = !(rdy && is_dram);

  for (genvar b = 0; b < NBANK; b++) begin : g_ce
    assign rom_ce_n[b] = !(req && !is_dram && bank == BKW'(b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) begin
        rws[i] <= '1;
        wws[i] <= '1;
      end
      ben <= '0;
    end else if (cfg_we) begin
      rws[cfg_bank] <= cfg_rws;
      wws[cfg_bank] <= cfg_wws;
      ben[cfg_bank] <= cfg_burst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_acc    <= 1'b0;
      need_q    <= '0;
      elapsed   <= '0;
      prev_rdy  <= 1'b0;
      last_addr <= '0;
      last_wr   <= 1'b0;
      pre_done  <= 1'b0;
    end else begin
      prev_rdy <= rdy;
      if (rdy) begin
        in_acc    <= 1'b0;
        elapsed   <= '0;
        last_addr <= addr;
        last_wr   <= wr;
      end else if (req) begin
        if (!in_acc) begin
          in_acc  <= 1'b1;
          need_q  <= need_c;
          elapsed <= CNTW'(1);
        end else begin
          elapsed <= elapsed + 1'b1;
        end
      end
      if (ras_n)                          pre_done <= 1'b1;
      else if (req && is_dram && !in_acc) pre_done <= 1'b0;
    end
  end
endmodule

module rom_dram_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic [AW-1:0] addr,
  input logic          rdy,
  input logic          ras_n,
  input logic          cas_n,
  input logic [3:0]    rom_ce_n
);
  AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) rdy |-> req); // R8
  AST_CAS_ON_RDY: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> (rdy && !ras_n)); // R8
  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~rom_ce_n)); // R9
  AST_RAS_CE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !ras_n |-> (&rom_ce_n)); // R9
  AST_CE_ON_ROM_REQ: assert property (@(posedge clk) disable iff (!rst_n) (req && !addr[AW-1]) |-> !(&rom_ce_n)); // R9
  AST_RAS_ON_DRAM_REQ: assert property (@(posedge clk) disable iff (!rst_n) (req && addr[AW-1]) |-> !ras_n); // R8
endmodule

bind rom_dram_seq rom_dram_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
  .rdy(rdy), .ras_n(ras_n), .cas_n(cas_n), .rom_ce_n(rom_ce_n)
);

// File: tb/rom_dram_seq_bench.sv
module rom_dram_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic        cfg_we = 1'b0, cfg_burst = 1'b0;
  logic [1:0]  cfg_bank = '0, cfg_rws = '0, cfg_wws = '0;
  logic        rdy, ras_n, cas_n;
  logic [3:0]  rom_ce_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rom_dram_seq u_rom_dram_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_rws(cfg_rws), .cfg_wws(cfg_wws),
    .cfg_burst(cfg_burst), .rdy(rdy), .ras_n(ras_n), .cas_n(cas_n), .rom_ce_n(rom_ce_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [11:0] a, input logic w, input int exp, input string tag);
    int n = 0;
    @(negedge clk);
    req = 1'b1; addr = a; wr = w;
    for (int k = 0; k < 16; k++) begin
      n++;
      #2;
      if (n == 1) begin
        if (a[11]) chk(!ras_n && &rom_ce_n, {tag, " R8 strobes"}, {ras_n, rom_ce_n}, 15);
        else chk(ras_n && rom_ce_n == ~(4'b1 << a[10:9]), {tag, " R9 ce"}, rom_ce_n, ~(4'b1 << a[10:9]) & 4'hf);
      end
      if (rdy) break;
      @(negedge clk);
    end
    chk(rdy && n == exp, {tag, " cycles"}, n, exp);
    if (a[11]) chk(!cas_n, {tag, " R8 cas"}, cas_n, 0);
    else chk(cas_n, {tag, " R8 cas idle"}, cas_n, 1);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req = 1'b0;
    #2;
    chk(!rdy && ras_n && cas_n && &rom_ce_n, "R9 idle outputs", {rdy, ras_n, cas_n, rom_ce_n}, 7'b0111111);
    for (int k = 1; k < n; k++) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] b, input logic [1:0] r, input logic [1:0] w, input logic bu);
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b1; cfg_bank = b; cfg_rws = r; cfg_wws = w; cfg_burst = bu;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    chk(!rdy && ras_n && cas_n && &rom_ce_n, "R1 reset outputs", {rdy, ras_n, cas_n, rom_ce_n}, 7'b0111111);
    run(12'h000, 0, 4, "R1 rd bank0");
    run(12'h001, 0, 4, "R1 rd consecutive no burst");
    run(12'h200, 1, 4, "R1 wr bank1");
    run(12'h600, 0, 4, "R1 rd bank3");
    idle(2);
  endtask

  task automatic t_waits();
    cfg(2'd0, 2'd0, 2'd1, 1'b0);
    cfg(2'd2, 2'd2, 2'd0, 1'b0);
    idle(1);
    run(12'h010, 0, 1, "R2 bank0 rd ws0");
    run(12'h020, 1, 2, "R2 bank0 wr ws1");
    run(12'h400, 0, 3, "R2 bank2 rd ws2");
    run(12'h410, 1, 1, "R2 bank2 wr ws0");
    run(12'h600, 1, 4, "R2 bank3 untouched");
    idle(2);
  endtask

  task automatic t_rom_burst();
    cfg(2'd1, 2'd1, 2'd1, 1'b1);
    idle(1);
    run(12'h200, 0, 2, "R3 first");
    run(12'h201, 0, 1, "R3 beat");
    run(12'h202, 0, 1, "R3 beat2");
    run(12'h204, 0, 2, "R3 jump");
    run(12'h205, 1, 2, "R3 dir change");
    run(12'h206, 1, 1, "R3 wr beat");
    idle(1);
    run(12'h207, 1, 2, "R3 after gap");
    idle(2);
  endtask

  task automatic t_dram();
    run(12'h800, 0, 2, "R5 after idle");
    run(12'h801, 0, 1, "R6 beat");
    run(12'h802, 0, 1, "R6 beat2");
    run(12'h80E, 0, 3, "R4 R7 jump");
    run(12'h80F, 0, 1, "R6 beat3");
    run(12'h810, 0, 3, "R7 row cross");
    idle(1);
    run(12'h900, 0, 2, "R5 one idle");
    run(12'h905, 0, 3, "R4 back to back");
    run(12'h010, 0, 1, "R2 rom between");
    run(12'hA00, 0, 2, "R5 rom hid precharge");
    run(12'hA01, 1, 3, "R7 dir change");
    run(12'hA02, 1, 1, "R6 wr beat");
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_waits();
    t_rom_burst();
    t_dram();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule